// File: doc/BRIEF.md
# DDR2 Burst Column Address Sequencer

This block produces the column address of every beat of one READ or WRITE burst in a DDR2-style memory controller. The controller pulses a start strobe together with the first column address, a burst length select (4 or 8 beats) and a burst order select (sequential or interleaved). Starting in the next cycle, the block emits one column address per clock with a valid flag. A last flag marks the final beat. Reads and writes use the same ordering.

The column bits above the burst block never change during a burst. Only the low bits step, so the burst wraps inside an aligned block of 4 or 8 columns. In 8-beat sequential mode the order works on nibbles: the two lowest bits count up modulo 4 in the starting half, then the same pattern repeats in the other half. In interleaved mode the low bits are the start bits XOR the beat number.

Control is a two-state machine. In `S_IDLE` the block waits. The transition *accept* (start high in `S_IDLE`) latches the inputs and moves to `S_BURST`. `S_BURST` holds while beats remain (transition *step*). The transition *finish* (final beat shown) returns to `S_IDLE`. The block spends at least one cycle in `S_IDLE` between bursts.

Top module: `burst_col_seq`

## Requirements
- R1: After reset, `valid_o` and `last_o` are low.
- R2: A start accepted in idle makes `valid_o` high in the next cycle. The first beat's `col_o` equals the `col_i` that was sampled with the start.
- R3: A burst shows exactly 4 valid beats when `len8_i`=0 and exactly 8 when `len8_i`=1, in consecutive cycles. `last_o` is high on the final beat only. `valid_o` is low in the cycle after the final beat.
- R4: During a burst, the block bits stay constant and equal to the start column. These are bits [COL_W-1:2] for 4 beats and bits [COL_W-1:3] for 8 beats.
- R5: With `ilv_i`=0 and 4 beats, beat i has col[1:0] = (start[1:0] + i) mod 4.
- R6: With `ilv_i`=0 and 8 beats, beat i has col[1:0] = (start[1:0] + i) mod 4. Its col[2] is start[2] for beats 0..3 and the inverse of start[2] for beats 4..7.
- R7: With `ilv_i`=1, beat i has col[1:0] = start[1:0] XOR i for 4 beats, and col[2:0] = start[2:0] XOR i for 8 beats.
- R8: While `valid_o` is high, including the final beat, `start_i` is ignored. Changes on `col_i`, `len8_i` and `ilv_i` do not alter the running burst. No new burst follows it.
- R9: A start driven in the first idle cycle after a burst is accepted, and the next burst begins one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start strobe for one burst |
| col_i | input | COL_W | Starting column address |
| len8_i | input | 1 | 1: 8-beat burst, 0: 4-beat burst |
| ilv_i | input | 1 | 1: interleaved order, 0: sequential order |
| col_o | output | COL_W | Column address of the current beat |
| valid_o | output | 1 | Beat present on `col_o` |
| last_o | output | 1 | Current beat is the final one |

## Verification
The assertions assume that reset is held for at least one clock before any checked cycle. They also assume that `col_i`, `len8_i` and `ilv_i` carry meaningful values only in the cycle where a start is accepted. The stimulus drives all inputs on the falling edge. It deliberately changes the start strobe and the mode and address inputs during bursts, including on the final beat, so that the ignore rule and the fixed block bits are exercised. Every start low-bit value is tried in every length and order combination, with varied block bits.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

    typedef enum logic [0:0] {
        S_IDLE  = 1'b0,
        S_BURST = 1'b1
    } seq_state_t;

    localparam int unsigned BEAT_W = 3;

    typedef struct packed {
        logic len8;
        logic ilv;
    } burst_mode_t;

endpackage

// File: rtl/burst_seq_fsm.sv
module burst_seq_fsm
    import burst_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic       at_last_i,
    output seq_state_t state_o,
    output logic       accept_o
);

    seq_state_t state_q;
    seq_state_t state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (start_i)   state_d = S_BURST;
            S_BURST: if (at_last_i) state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_o  = state_q;
        accept_o = (state_q == S_IDLE) && start_i;
    end

endmodule

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr
    import burst_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              run_i,
    input  logic              len8_i,
    output logic [BEAT_W-1:0] beat_o,
    output logic              at_last_o
);

    localparam logic [BEAT_W-1:0] LAST4 = BEAT_W'(3);
    localparam logic [BEAT_W-1:0] LAST8 = BEAT_W'(7);

    logic [BEAT_W-1:0] beat_q;

    always_comb begin
        at_last_o = run_i && (beat_q == (len8_i ? LAST8 : LAST4));
        beat_o    = beat_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            beat_q <= '0;
        end else if (clear_i || at_last_o) begin
            beat_q <= '0;
        end else if (run_i) begin
            beat_q <= beat_q + BEAT_W'(1);
        end
    end

endmodule

// File: rtl/burst_order_calc.sv
module burst_order_calc
    import burst_seq_pkg::*;
#(
    parameter int unsigned COL_W = 10
) (
    input  logic [COL_W-1:0]  base_i,
    input  logic [BEAT_W-1:0] beat_i,
    input  burst_mode_t       mode_i,
    output logic [COL_W-1:0]  col_o
);

    localparam int unsigned HI_W = COL_W - BEAT_W;

    logic [1:0]        nib_sum;
    logic [BEAT_W-1:0] low;

    always_comb begin
        nib_sum = base_i[1:0] + beat_i[1:0];
        low     = base_i[BEAT_W-1:0];
        if (mode_i.ilv) begin
            if (mode_i.len8) low = base_i[2:0] ^ beat_i;
            else             low = {base_i[2], base_i[1:0] ^ beat_i[1:0]};
        end else begin
            if (mode_i.len8) low = {base_i[2] ^ beat_i[2], nib_sum};
            else             low = {base_i[2], nib_sum};
        end
        col_o = {base_i[COL_W-1 -: HI_W], low};
    end

endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
    import burst_seq_pkg::*;
#(
    parameter int unsigned COL_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [COL_W-1:0] col_i,
    input  logic             len8_i,
    input  logic             ilv_i,
    output logic [COL_W-1:0] col_o,
    output logic             valid_o,
    output logic             last_o
);

    seq_state_t        state;
    logic              accept;
    logic              at_last;
    logic              running;
    logic [BEAT_W-1:0] beat;
    logic [COL_W-1:0]  base_q;
    burst_mode_t       mode_q;
    logic [COL_W-1:0]  col_calc;

    burst_seq_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .at_last_i (at_last),
        .state_o   (state),
        .accept_o  (accept)
    );

    assign running = (state == S_BURST);

    burst_beat_ctr u_ctr (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_i   (accept),
        .run_i     (running),
        .len8_i    (mode_q.len8),
        .beat_o    (beat),
        .at_last_o (at_last)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            mode_q <= '0;
        end else if (accept) begin
            base_q <= col_i;
            mode_q <= '{len8: len8_i, ilv: ilv_i};
        end
    end

    burst_order_calc #(.COL_W(COL_W)) u_order (
        .base_i (base_q),
        .beat_i (beat),
        .mode_i (mode_q),
        .col_o  (col_calc)
    );

    always_comb begin
        valid_o = running;
        last_o  = running && at_last;
        col_o   = col_calc;
    end

endmodule

// File: rtl/burst_col_seq_chk.sv
module burst_col_seq_chk #(
    parameter int unsigned COL_W = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic [COL_W-1:0] col_i,
    input logic [COL_W-1:0] col_o,
    input logic             valid_o,
    input logic             last_o,
    input logic             mode_len8
);

    // R2
    start_beat0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !valid_o) |=> (valid_o && col_o == $past(col_i)));

    // R3
    last_in_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        last_o |-> valid_o);

    // R3
    gap_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        last_o |=> !valid_o);

    // R3
    no_early_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !last_o) |=> valid_o);

    // R4
    block_hi_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && $past(valid_o)) |-> (col_o[COL_W-1:3] == $past(col_o[COL_W-1:3])));

    // R4
    block_b2_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && $past(valid_o) && !mode_len8) |-> (col_o[2] == $past(col_o[2])));

endmodule

bind burst_col_seq burst_col_seq_chk #(.COL_W(COL_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .col_i     (col_i),
    .col_o     (col_o),
    .valid_o   (valid_o),
    .last_o    (last_o),
    .mode_len8 (mode_q.len8)
);

// File: tb/burst_col_seq_bench.sv
`timescale 1ns/1ps
module burst_col_seq_bench;

    localparam int unsigned COL_W = 10;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start_i = 1'b0;
    logic [COL_W-1:0] col_i = '0;
    logic             len8_i = 1'b0;
    logic             ilv_i = 1'b0;
    logic [COL_W-1:0] col_o;
    logic             valid_o;
    logic             last_o;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    burst_col_seq #(.COL_W(COL_W)) u_burst_col_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .col_i   (col_i),
        .len8_i  (len8_i),
        .ilv_i   (ilv_i),
        .col_o   (col_o),
        .valid_o (valid_o),
        .last_o  (last_o)
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000 && !done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=%0d cycles expected=<50000", cyc);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [COL_W-1:0] exp_col(input logic [COL_W-1:0] s,
                                                 input bit l8, input bit il, input int i);
        logic [COL_W-1:0] r;
        logic [2:0] bi;
        bi = 3'(i);
        r = s;
        if (il) begin
            if (l8) r[2:0] = s[2:0] ^ bi;
            else    r[1:0] = s[1:0] ^ bi[1:0];
        end else begin
            r[1:0] = 2'(s[1:0] + bi[1:0]);
            if (l8 && i >= 4) r[2] = ~s[2];
        end
        return r;
    endfunction

    // Caller stands at a falling edge; start is driven now.
    task automatic run_burst(input logic [COL_W-1:0] s, input bit l8, input bit il,
                             input string req, input bit noise);
        int n;
        n = l8 ? 8 : 4;
        start_i = 1'b1; col_i = s; len8_i = l8; ilv_i = il;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (noise) begin
                start_i = 1'b1; col_i = ~s; len8_i = ~l8; ilv_i = ~il;
            end else begin
                start_i = 1'b0; col_i = 'x; len8_i = 1'bx; ilv_i = 1'bx;
            end
            chk(valid_o === 1'b1, i == 0 ? "R2 valid" : "R3 valid", int'(valid_o), 1);
            chk(col_o === exp_col(s, l8, il, i), req, int'(col_o), int'(exp_col(s, l8, il, i)));
            chk(last_o === (i == n - 1), "R3 last", int'(last_o), int'(i == n - 1));
            if (l8) chk(col_o[COL_W-1:3] === s[COL_W-1:3], "R4 block8", int'(col_o), int'(s));
            else    chk(col_o[COL_W-1:2] === s[COL_W-1:2], "R4 block4", int'(col_o), int'(s));
        end
        @(negedge clk);
        start_i = 1'b0;
        chk(valid_o === 1'b0, noise ? "R8 no restart" : "R3 end", int'(valid_o), 0);
        chk(last_o === 1'b0, "R3 last low", int'(last_o), 0);
    endtask

    task automatic test_reset();
        @(negedge clk);
        chk(valid_o === 1'b0, "R1 valid", int'(valid_o), 0);
        chk(last_o === 1'b0, "R1 last", int'(last_o), 0);
    endtask

    task automatic test_seq4();
        @(negedge clk);
        for (int k = 0; k < 8; k++) run_burst(COL_W'(10'h2A4 + k * 37), 1'b0, 1'b0, "R5 seq4", 1'b0);
    endtask

    task automatic test_seq8();
        @(negedge clk);
        for (int k = 0; k < 8; k++) run_burst(COL_W'(10'h1C0 + k * 9), 1'b1, 1'b0, "R6 seq8", 1'b0);
    endtask

    task automatic test_ilv();
        @(negedge clk);
        for (int k = 0; k < 8; k++) run_burst(COL_W'(10'h358 + k * 5), 1'b0, 1'b1, "R7 ilv4", 1'b0);
        for (int k = 0; k < 8; k++) run_burst(COL_W'(10'h0F0 + k * 13), 1'b1, 1'b1, "R7 ilv8", 1'b0);
    endtask

    task automatic test_ignore();
        @(negedge clk);
        run_burst(10'h2F5, 1'b1, 1'b0, "R8 seq8 noisy", 1'b1);
        @(negedge clk);
        chk(valid_o === 1'b0, "R8 still idle", int'(valid_o), 0);
        run_burst(10'h10E, 1'b0, 1'b1, "R8 ilv4 noisy", 1'b1);
    endtask

    task automatic test_back2back();
        @(negedge clk);
        run_burst(10'h3FF, 1'b1, 1'b1, "R9 first", 1'b0);
        run_burst(10'h001, 1'b0, 1'b0, "R9 second", 1'b0);
        run_burst(10'h206, 1'b1, 1'b0, "R9 third", 1'b0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        test_reset();
        rst_n = 1'b1;
        @(negedge clk);
        chk(valid_o === 1'b0, "R1 idle after reset", int'(valid_o), 0);
        test_seq4();
        test_seq8();
        test_ilv();
        test_ignore();
        test_back2back();
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule